// File: doc/BRIEF.md
# Debug Signal Lane Multiplexer

This block is one node in an on-chip network that routes internal debug signals towards an observation point. It takes a set of 16-bit signal groups from the local unit, a set of 8-bit lanes from multiplexers further upstream, and a set of clock-tag bits. It produces a parameterised number of 8-bit output lanes. Each output lane carries a companion clock-tag bit. The block also produces one single-bit crossbar output that can tap any bit of any local byte.

Every output lane has its own 32-bit control word. The word picks a source, a clock tag, a pass-through of the upstream lane with the same index, a right shift of a 16-bit group, and an optional second source for the upper nibble. A global word switches the node on and off, and it can replace all routed lanes with a counting test pattern. Software programs these words through a plain write-only register port.

Outputs are registered, so every output reflects the inputs and configuration that were present at the previous clock edge. The node samples its inputs continuously and drives its outputs continuously, so there is no valid/ready handshake and no back-pressure: a downstream consumer observes the lanes on every cycle.

Top module: `dbg_lane_mux`

## Requirements
- R1: While reset is asserted and directly after it, every lane output, every lane clock tag and the crossbar output read zero.
- R2: Word address 0 is the global word. Addresses 1 to NUM_LANES hold the lane words for lanes 0 upward. Address NUM_LANES+1 holds the crossbar word. A write to any other address has no effect. A write is accepted at a clock edge, and the outputs show it from the next edge on.
- R3: When global bit 0 (enable) is 0, all lane outputs, clock tags and the crossbar output are zero, whatever the other settings are.
- R4: When the node is enabled and global bits 7:4 (pattern mode) are nonzero, every lane shows the same 8-bit counter. The counter reads 0 on the first cycle of the mode, rises by one per cycle and wraps at 255. The counter restarts from 0 each time the mode is entered again.
- R5: Lane word bits 7:0 select the source. Values 0 to NUM_GROUPS-1 pick a local group. Values NUM_GROUPS to NUM_GROUPS+NUM_UP-1 pick upstream lane (value-NUM_GROUPS).
- R6: Lane word bits 22:20 give a shift of 0 to 7. A selected local group is shifted right by this many bits, and its low 8 bits are taken. Upstream sources are not shifted.
- R7: Lane word bit 16 set makes the lane pass the upstream lane with the same index unchanged. The select field and the upper-nibble field are then ignored.
- R8: Lane word bits 31:24, when nonzero, name a second source numbered (value-1), using the R5 numbering and the R6 shift. Output bits 7:4 come from that source and bits 3:0 from the primary source. A second source out of range gives zero in bits 7:4.
- R9: Lane word bits 15:8 pick which clock-tag input the lane's clock output follows. A value of NUM_CLK or above gives zero. The clock tag is also routed in pattern mode.
- R10: A primary select of NUM_GROUPS+NUM_UP or above drives zero on the lane.
- R11: In the crossbar word, bits 15:8 pick byte k of the local groups, where byte k is bits 8k+7:8k of the concatenated groups with group 0 lowest. Bits 2:0 pick the bit within that byte. Setting bit 3 instead passes bit 0 of upstream lane 0. Pattern mode does not affect the crossbar output.
- R12: A crossbar byte select of 2*NUM_GROUPS or above drives the crossbar output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| grp_in | input | NUM_GROUPS*16 | Local 16-bit signal groups, group 0 in the low bits |
| up_in | input | NUM_UP*8 | Upstream 8-bit lanes, lane 0 in the low bits |
| clk_tag_in | input | NUM_CLK | Clock-tag candidates |
| lane_out | output | NUM_LANES*8 | Output lanes, lane 0 in the low bits |
| lane_clk_out | output | NUM_LANES | Clock tag routed with each lane |
| xbar_out | output | 1 | Crossbar single-bit output |

## Verification
The lanes are driven with fresh pseudo-random group, upstream and clock-tag values on every cycle, so a wrong source, a wrong shift amount or a nibble taken from the wrong operand shows up within a few cycles. Each select value is swept, including the first and last of both the group range and the upstream range and values past the end, which separates an off-by-one in the source numbering from a missing range check. All eight shifts are applied to one group, which distinguishes the shift direction and the shift amount. Bypass is combined with an out-of-range select, and pattern mode is run long enough to wrap; this shows whether the mode priority and the counter's restart from zero are correct.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  localparam int LANE_W = 8;
  localparam int GRP_W  = 16;
  localparam int CFG_W  = 32;

  // lane word fields
  function automatic logic [7:0] lw_src(input logic [CFG_W-1:0] w);
    return w[7:0];
  endfunction
  function automatic logic [7:0] lw_clk(input logic [CFG_W-1:0] w);
    return w[15:8];
  endfunction
  function automatic logic lw_thru(input logic [CFG_W-1:0] w);
    return w[16];
  endfunction
  function automatic logic [2:0] lw_shift(input logic [CFG_W-1:0] w);
    return w[22:20];
  endfunction
  function automatic logic [7:0] lw_hi_src(input logic [CFG_W-1:0] w);
    return w[31:24];
  endfunction

  // crossbar word fields
  function automatic logic [2:0] xw_bit(input logic [CFG_W-1:0] w);
    return w[2:0];
  endfunction
  function automatic logic xw_thru(input logic [CFG_W-1:0] w);
    return w[3];
  endfunction
  function automatic logic [7:0] xw_byte(input logic [CFG_W-1:0] w);
    return w[15:8];
  endfunction
endpackage

// File: rtl/dlm_pattern_gen.sv
module dlm_pattern_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (run) cnt_o <= cnt_o + 1'b1;
    else          cnt_o <= '0;
  end

  // R4: counter advances by one on every cycle of an ongoing run
  p_pat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (cnt_o == $past(cnt_o) + 1'b1));

  // R4: a fresh run starts from zero
  p_pat_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> (cnt_o == '0));
endmodule

// File: rtl/dlm_lane_sel.sv
module dlm_lane_sel
  import dlm_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_UP     = 4,
  parameter int NUM_CLK    = 4,
  parameter int LANE_IDX   = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CFG_W-1:0]            cfg,
  input  logic [NUM_GROUPS*GRP_W-1:0] grp_in,
  input  logic [NUM_UP*LANE_W-1:0]    up_in,
  input  logic [NUM_CLK-1:0]          clk_tag_in,
  output logic [LANE_W-1:0]           data_o,
  output logic                        tag_o
);
  localparam int NUM_SRC = NUM_GROUPS + NUM_UP;

  logic [LANE_W-1:0] prim, hi, thru_val;
  logic [7:0]        hi_idx;
  logic              unused_rsv;

  assign unused_rsv = ^{cfg[19:17], cfg[23]};
  assign hi_idx     = lw_hi_src(cfg) - 8'd1;

  function automatic logic [LANE_W-1:0] fetch(
    input logic [7:0]                  s,
    input logic [2:0]                  sh,
    input logic [NUM_GROUPS*GRP_W-1:0] g_v,
    input logic [NUM_UP*LANE_W-1:0]    u_v
  );
    logic [LANE_W-1:0] r;
    logic [GRP_W-1:0]  t;
    r = '0;
    t = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (s == 8'(g)) begin
        t = g_v[g*GRP_W +: GRP_W] >> sh;
        r = t[LANE_W-1:0];
      end
    end
    for (int u = 0; u < NUM_UP; u++) begin
      if (s == 8'(NUM_GROUPS + u)) r = u_v[u*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  generate
    if (LANE_IDX < NUM_UP) begin : g_thru
      assign thru_val = up_in[LANE_IDX*LANE_W +: LANE_W];
    end else begin : g_nothru
      assign thru_val = '0;
    end
  endgenerate

  always_comb begin
    prim = fetch(lw_src(cfg), lw_shift(cfg), grp_in, up_in);
    hi   = fetch(hi_idx, lw_shift(cfg), grp_in, up_in);
    if (lw_thru(cfg))             data_o = thru_val;
    else if (lw_hi_src(cfg) != 0) data_o = {hi[7:4], prim[3:0]};
    else                          data_o = prim;
  end

  always_comb begin
    tag_o = 1'b0;
    for (int c = 0; c < NUM_CLK; c++) begin
      if (lw_clk(cfg) == 8'(c)) tag_o = clk_tag_in[c];
    end
  end

  // R10: out-of-range primary select yields zero
  p_src_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[16] && cfg[31:24] == 8'd0 && cfg[7:0] >= 8'(NUM_SRC)) |-> (data_o == '0));

  // R9: out-of-range clock select yields zero
  p_clk_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[15:8] >= 8'(NUM_CLK)) |-> !tag_o);
endmodule

// File: rtl/dlm_xbar.sv
module dlm_xbar
  import dlm_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CFG_W-1:0]            cfg,
  input  logic [NUM_GROUPS*GRP_W-1:0] grp_in,
  input  logic                        up0_bit,
  output logic                        bit_o
);
  localparam int NUM_BYTES = NUM_GROUPS * GRP_W / 8;

  logic [7:0] pick;
  logic       hit;
  logic       unused_rsv;

  assign unused_rsv = ^{cfg[7:4], cfg[31:16]};

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (xw_byte(cfg) == 8'(k)) begin
        pick = grp_in[k*8 +: 8];
        hit  = 1'b1;
      end
    end
    if (xw_thru(cfg)) bit_o = up0_bit;
    else if (hit)     bit_o = pick[xw_bit(cfg)];
    else              bit_o = 1'b0;
  end

  // R12: byte select past the last local byte yields zero
  p_byte_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[3] && cfg[15:8] >= 8'(NUM_BYTES)) |-> !bit_o);
endmodule

// File: rtl/dbg_lane_mux.sv
module dbg_lane_mux
  import dlm_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_UP     = 4,
  parameter int NUM_CLK    = 4,
  parameter int ADDR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [CFG_W-1:0]            reg_wdata,
  input  logic [NUM_GROUPS*GRP_W-1:0] grp_in,
  input  logic [NUM_UP*LANE_W-1:0]    up_in,
  input  logic [NUM_CLK-1:0]          clk_tag_in,
  output logic [NUM_LANES*LANE_W-1:0] lane_out,
  output logic [NUM_LANES-1:0]        lane_clk_out,
  output logic                        xbar_out
);
  localparam int XBAR_ADDR = NUM_LANES + 1;

  logic              glb_en;
  logic [3:0]        glb_pg;
  logic [CFG_W-1:0]  lane_cfg [NUM_LANES];
  logic [CFG_W-1:0]  xbar_cfg;
  logic              pg_run;
  logic [LANE_W-1:0] pat;
  logic [LANE_W-1:0] lane_d [NUM_LANES];
  logic [LANE_W-1:0] lane_q [NUM_LANES];
  logic [NUM_LANES-1:0] tag_d;
  logic              xbar_d;

  // configuration store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      glb_pg   <= '0;
      xbar_cfg <= '0;
      for (int i = 0; i < NUM_LANES; i++) lane_cfg[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == '0) begin
        glb_en <= reg_wdata[0];
        glb_pg <= reg_wdata[7:4];
      end
      if (reg_addr == ADDR_W'(XBAR_ADDR)) xbar_cfg <= reg_wdata;
      for (int i = 0; i < NUM_LANES; i++) begin
        if (reg_addr == ADDR_W'(i + 1)) lane_cfg[i] <= reg_wdata;
      end
    end
  end

  assign pg_run = glb_en && (glb_pg != 4'd0);

  dlm_pattern_gen #(.W(LANE_W)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pg_run),
    .cnt_o (pat)
  );

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      dlm_lane_sel #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_UP     (NUM_UP),
        .NUM_CLK    (NUM_CLK),
        .LANE_IDX   (i)
      ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (lane_cfg[i]),
        .grp_in     (grp_in),
        .up_in      (up_in),
        .clk_tag_in (clk_tag_in),
        .data_o     (lane_d[i]),
        .tag_o      (tag_d[i])
      );
    end
  endgenerate

  dlm_xbar #(.NUM_GROUPS(NUM_GROUPS)) u_xbar (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (xbar_cfg),
    .grp_in  (grp_in),
    .up0_bit (up_in[0]),
    .bit_o   (xbar_d)
  );

  // output stage: disable > pattern > routed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_clk_out <= '0;
      xbar_out     <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) lane_q[i] <= '0;
    end else begin
      lane_clk_out <= glb_en ? tag_d : '0;
      xbar_out     <= glb_en & xbar_d;
      for (int i = 0; i < NUM_LANES; i++) begin
        if (!glb_en)     lane_q[i] <= '0;
        else if (pg_run) lane_q[i] <= pat;
        else             lane_q[i] <= lane_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) lane_out[i*LANE_W +: LANE_W] = lane_q[i];
  end

  // R3: a disabled node shows nothing on the following cycle
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (lane_out == '0 && lane_clk_out == '0 && !xbar_out));

  // R4: in pattern mode all lanes agree
  p_pat_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_run |=> (lane_out[LANE_W-1:0] == lane_out[NUM_LANES*LANE_W-1 -: LANE_W]));

  // R7: pass-through on lane 0 copies upstream lane 0 one cycle later
  p_thru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !pg_run && lane_cfg[0][16]) |=> (lane_out[LANE_W-1:0] == $past(up_in[LANE_W-1:0])));
endmodule

// File: tb/dbg_lane_mux_test.sv
`timescale 1ns/1ps
module dbg_lane_mux_test;
  localparam int NL = 4, NG = 4, NU = 4, NC = 4, AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [15:0]   grp_m [NG];
  logic [7:0]    up_m [NU];
  logic [NC-1:0] ctag;
  logic [NG*16-1:0] grp_flat;
  logic [NU*8-1:0]  up_flat;
  logic [NL*8-1:0]  lane_out;
  logic [NL-1:0]    lane_clk_out;
  logic             xbar_out;

  for (genvar g = 0; g < NG; g++) begin : g_gf
    assign grp_flat[g*16 +: 16] = grp_m[g];
  end
  for (genvar u = 0; u < NU; u++) begin : g_uf
    assign up_flat[u*8 +: 8] = up_m[u];
  end

  dbg_lane_mux #(.NUM_LANES(NL), .NUM_GROUPS(NG), .NUM_UP(NU), .NUM_CLK(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .grp_in(grp_flat), .up_in(up_flat), .clk_tag_in(ctag),
    .lane_out(lane_out), .lane_clk_out(lane_clk_out), .xbar_out(xbar_out)
  );

  // behavioural model state
  bit        m_en;
  bit [3:0]  m_pg;
  bit [31:0] m_lane [NL];
  bit [31:0] m_x;
  int        m_cnt;
  logic [7:0] e_lane [NL];
  logic       e_tag [NL];
  logic       e_x;

  string cur_req = "R1";
  int n_cmp = 0, n_bad = 0;
  bit checking = 0, done = 0;

  function automatic logic [7:0] src_val(int s, int sh);
    if (s < NG)      return 8'((grp_m[s] >> sh) & 16'h00FF);
    if (s < NG + NU) return up_m[s - NG];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pg = 0; m_x = 0; m_cnt = 0;
      for (int i = 0; i < NL; i++) begin m_lane[i] = 0; e_lane[i] = 0; e_tag[i] = 0; end
      e_x = 0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        int s, sh, hs, cs;
        logic [7:0] p, h;
        s  = int'(m_lane[i][7:0]);
        sh = int'(m_lane[i][22:20]);
        hs = int'(m_lane[i][31:24]);
        cs = int'(m_lane[i][15:8]);
        p = src_val(s, sh);
        if (!m_en) e_lane[i] = 0;
        else if (m_pg != 0) e_lane[i] = 8'(m_cnt);
        else if (m_lane[i][16]) e_lane[i] = up_m[i];
        else if (hs != 0) begin h = src_val(hs - 1, sh); e_lane[i] = {h[7:4], p[3:0]}; end
        else e_lane[i] = p;
        e_tag[i] = m_en && (cs < NC) ? ctag[cs] : 1'b0;
      end
      if (!m_en) e_x = 0;
      else if (m_x[3]) e_x = up_m[0][0];
      else if (int'(m_x[15:8]) < 2 * NG) begin
        int b;
        b = int'(m_x[15:8]);
        e_x = grp_m[b / 2][8 * (b % 2) + int'(m_x[2:0])];
      end else e_x = 0;
      if (m_en && m_pg != 0) m_cnt = (m_cnt + 1) % 256; else m_cnt = 0;
      if (reg_we) begin
        if (reg_addr == 0) begin m_en = reg_wdata[0]; m_pg = reg_wdata[7:4]; end
        else if (reg_addr >= 1 && reg_addr <= NL) m_lane[reg_addr - 1] = reg_wdata;
        else if (reg_addr == NL + 1) m_x = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      for (int i = 0; i < NL; i++) begin
        n_cmp++;
        if (lane_out[i*8 +: 8] !== e_lane[i]) begin
          n_bad++;
          $display("FAIL %s lane %0d data: actual %h expected %h", cur_req, i, lane_out[i*8 +: 8], e_lane[i]);
        end
        n_cmp++;
        if (lane_clk_out[i] !== e_tag[i]) begin
          n_bad++;
          $display("FAIL %s lane %0d clock tag: actual %b expected %b", cur_req, i, lane_clk_out[i], e_tag[i]);
        end
      end
      n_cmp++;
      if (xbar_out !== e_x) begin
        n_bad++;
        $display("FAIL %s crossbar bit: actual %b expected %b", cur_req, xbar_out, e_x);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      for (int g = 0; g < NG; g++) grp_m[g] = 16'($urandom);
      for (int u = 0; u < NU; u++) up_m[u] = 8'($urandom);
      ctag = NC'($urandom);
    end
  endtask

  function automatic logic [31:0] lw(int src, int clks, bit thru, int sh, int hi);
    return {8'(hi), 1'b0, 3'(sh), 3'b000, thru, 8'(clks), 8'(src)};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; ctag = 0;
    for (int g = 0; g < NG; g++) grp_m[g] = 16'hFFFF;
    for (int u = 0; u < NU; u++) up_m[u] = 8'hFF;
    repeat (2) @(negedge clk);
    checking = 1;
    cur_req = "R1"; run(3);
    rst_n = 1;
    run(3);

    cur_req = "R3";
    for (int i = 0; i < NL; i++) wr(1 + i, lw(i, i, 0, 0, 0));
    wr(NL + 1, 32'h0000_0105);
    run(6);

    cur_req = "R2";
    wr(0, 32'h1);
    wr(15, 32'hFFFF_FFFF);
    wr(NL + 2, 32'h0001_0000);
    run(6);

    cur_req = "R5";
    for (int s = 0; s < NG + NU; s++) begin
      wr(1, lw(s, 0, 0, 0, 0));
      wr(2, lw(NG + NU - 1 - s, 1, 0, 0, 0));
      run(3);
    end

    cur_req = "R6";
    for (int sh = 0; sh < 8; sh++) begin
      wr(1, lw(2, 0, 0, sh, 0));
      wr(2, lw(NG + 1, 0, 0, sh, 0));
      run(3);
    end

    cur_req = "R7";
    for (int i = 0; i < NL; i++) wr(1 + i, lw(8'h20, i, 1, 5, 3));
    run(5);

    cur_req = "R8";
    wr(1, lw(1, 0, 0, 0, NG + 2));
    wr(2, lw(NG, 0, 0, 4, 1));
    wr(3, lw(3, 0, 0, 7, NG + NU));
    wr(4, lw(0, 0, 0, 2, 8'hFF));
    run(6);

    cur_req = "R9";
    for (int c = 0; c < NC + 2; c++) begin
      for (int i = 0; i < NL; i++) wr(1 + i, lw(i, (c + i) % (NC + 2), 0, 0, 0));
      run(4);
    end
    wr(1, lw(0, 8'hFF, 0, 0, 0));
    run(4);

    cur_req = "R10";
    wr(1, lw(NG + NU, 0, 0, 0, 0));
    wr(2, lw(8'h80, 1, 0, 0, 0));
    wr(3, lw(8'hFF, 2, 0, 3, 0));
    run(5);

    cur_req = "R11";
    for (int b = 0; b < 2 * NG; b++) begin
      wr(NL + 1, {16'h0, 8'(b), 5'b0, 3'(b + 3)});
      run(3);
    end
    wr(NL + 1, {16'h0, 8'd2, 4'h0, 1'b1, 3'd6});
    run(5);

    cur_req = "R12";
    wr(NL + 1, {16'h0, 8'(2 * NG), 8'h07});
    run(4);
    wr(NL + 1, {16'h0, 8'hFF, 8'h01});
    run(4);

    cur_req = "R4";
    for (int i = 0; i < NL; i++) wr(1 + i, lw(i, i, 0, 0, 0));
    wr(NL + 1, {16'h0, 8'd1, 8'h02});
    wr(0, 32'h0000_0031);
    run(300);
    wr(0, 32'h1);
    run(5);
    wr(0, 32'h0000_00F1);
    run(20);

    cur_req = "R3";
    wr(0, 32'h0000_0050);
    run(6);
    wr(0, 32'h0);
    run(6);

    finish_run();
  end
endmodule